// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a byte-wide path into a set of 51 internal byte registers while using only two visible locations. The host first writes a command byte to the command location. The command names a register group and a register within that group. The host then moves that register's bytes through the data location, one byte per access. It may read or write each byte.

The byte count of every transfer is fixed by the register that was named. The host does not choose it. Inside the block, a down-counter tracks the bytes that are still owed and a pointer steps through the bytes of a multi-byte register. One aggregate command covers the whole mapping group: it reads or writes all mapping registers as one continuous stream. The block stores only the register contents. Whatever consumes those coefficients lives elsewhere.

The host selects a location with `hostSel`. Low selects command (on write) or status (on read). High selects data. Read data is combinational from the current state and is valid while `hostRd` is high. A read or write takes effect at the rising clock edge.

Top module: `irp_port`

## Requirements
- R1: A command byte carries the group in bits 7:5 and the register number in bits 4:0. The group codes are 3'b001 for init, 3'b010 for the multiplexer and 3'b011 for mapping. Equal register numbers in different groups address different storage.
- R2: The number of data bytes owed after a command depends only on the register:
  - 0x21, 0x41, 0x42, 0x43 and 0x44 take 1 byte each.
  - 0x61 and 0x62 take 16 bytes each.
  - 0x63 to 0x68 take 2 bytes each.
  - 0x69 and 0x6A take 1 byte each.
- R3: Command 0x6B owes 46 bytes. Those bytes are the registers 0x61 to 0x6A laid end to end in ascending register order. A byte written through 0x6B is the same storage as that byte reached through its own register, and the reverse also holds.
- R4: Bytes of a multi-byte register move least significant first. Each data access, read or write, advances to the next byte. A byte written reads back unchanged.
- R5: Once the owed count reaches zero, further data writes change nothing and data reads return 0x00.
- R6: A command write restarts sequencing at once, even partway through a transfer. The bytes already moved keep their values.
- R7: A command byte not listed in R2 or R3 owes zero bytes and sets a sticky error flag. The flag reads as bit 0 of the status byte and is cleared by a status read.
- R8: Bit 1 of the status byte is 1 while bytes are still owed and 0 otherwise. Bits 7:2 of the status byte read 0.
- R9: After reset, every stored byte is 0x00, the status byte is 0x00 and a data read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Location select: 0 selects command/status, 1 selects data |
| hostWr | input | 1 | Write strobe, one access per cycle held high |
| hostRd | input | 1 | Read strobe, one access per cycle held high |
| hostWdata | input | 8 | Byte written by the host |
| hostRdata | output | 8 | Status byte or data byte, depending on `hostSel` |

## Verification
The bench builds the block with its default parameters:
- 16-byte coefficient registers;
- six 2-byte gain registers;
- four multiplexer registers.

These values give the 46-byte aggregate and the code 0x6B. They also put the mapping group at the bottom of a 51-byte store, so the exact edges of every register are within reach. The bench checks where the 16-byte pair meets the gain registers and where the last gain register meets the two mode bytes. It checks the top of the aggregate stream and the first access after a count runs out. Invalid codes are mixed in among the group boundaries: 0x6C just above the aggregate, 0x45 just above the multiplexer group, 0x20 and 0x80.

// File: rtl/irp_pkg.sv
package irp_pkg;

  localparam logic [2:0] SUB_INIT = 3'b001;
  localparam logic [2:0] SUB_MUX  = 3'b010;
  localparam logic [2:0] SUB_MAP  = 3'b011;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrByte;    // store hostWdata at the pointer
    logic byteLive;  // data location selected with bytes still owed
  } dpStrobe_t;

endpackage

// File: rtl/irp_decode.sv
module irp_decode #(
  parameter int COEF_BYTES = 16,
  parameter int GAIN_REGS  = 6,
  parameter int MUX_REGS   = 4,
  parameter int PTR_W      = 6,
  parameter int CNT_W      = 6
) (
  input  logic [7:0]       cmdByte,
  output logic [PTR_W-1:0] cmdBase,
  output logic [CNT_W-1:0] cmdLen,
  output logic             cmdValid
);
  import irp_pkg::*;

  localparam int GAIN_BASE = 2 * COEF_BYTES;
  localparam int MODE_BASE = GAIN_BASE + 2 * GAIN_REGS;
  localparam int MAP_BYTES = MODE_BASE + 2;
  localparam int MUX_BASE  = MAP_BYTES;
  localparam int INIT_BASE = MUX_BASE + MUX_REGS;
  localparam int GAIN_LO   = 3;
  localparam int GAIN_HI   = GAIN_LO + GAIN_REGS - 1;
  localparam int MODE_A    = GAIN_HI + 1;
  localparam int MODE_B    = GAIN_HI + 2;
  localparam int AGGR_IDX  = GAIN_HI + 3;

  logic [2:0] subSel;
  int         regIdx;

  assign subSel = cmdByte[7:5];
  assign regIdx = int'(cmdByte[4:0]);

  always_comb begin
    cmdBase  = '0;
    cmdLen   = '0;
    cmdValid = 1'b0;
    case (subSel)
      SUB_INIT: begin
        if (regIdx == 1) begin
          cmdBase  = PTR_W'(INIT_BASE);
          cmdLen   = CNT_W'(1);
          cmdValid = 1'b1;
        end
      end
      SUB_MUX: begin
        if (regIdx >= 1 && regIdx <= MUX_REGS) begin
          cmdBase  = PTR_W'(MUX_BASE + regIdx - 1);
          cmdLen   = CNT_W'(1);
          cmdValid = 1'b1;
        end
      end
      SUB_MAP: begin
        if (regIdx == 1 || regIdx == 2) begin
          cmdBase  = PTR_W'((regIdx - 1) * COEF_BYTES);
          cmdLen   = CNT_W'(COEF_BYTES);
          cmdValid = 1'b1;
        end else if (regIdx >= GAIN_LO && regIdx <= GAIN_HI) begin
          cmdBase  = PTR_W'(GAIN_BASE + 2 * (regIdx - GAIN_LO));
          cmdLen   = CNT_W'(2);
          cmdValid = 1'b1;
        end else if (regIdx == MODE_A || regIdx == MODE_B) begin
          cmdBase  = PTR_W'(MODE_BASE + regIdx - MODE_A);
          cmdLen   = CNT_W'(1);
          cmdValid = 1'b1;
        end else if (regIdx == AGGR_IDX) begin
          cmdBase  = '0;
          cmdLen   = CNT_W'(MAP_BYTES);
          cmdValid = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R2: a valid decode never owes zero bytes
  always_comb begin
    if (cmdValid) begin
      a_r2_len_nonzero: assert (cmdLen != '0);
    end
  end

endmodule

// File: rtl/irp_ctrl.sv
module irp_ctrl #(
  parameter int PTR_W     = 6,
  parameter int CNT_W     = 6,
  parameter int MAP_BYTES = 46
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostSel,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [PTR_W-1:0]    cmdBase,
  input  logic [CNT_W-1:0]    cmdLen,
  input  logic                cmdValid,
  output logic [PTR_W-1:0]    bytePtr,
  output irp_pkg::dpStrobe_t  dpStb,
  output logic [7:0]          statusByte
);
  import irp_pkg::*;

  logic [PTR_W-1:0] ptrQ;
  logic [CNT_W-1:0] remainQ;
  logic             errQ;
  logic             cmdWr, statRd, dataAcc, live;

  assign cmdWr   = hostWr && !hostSel;
  assign statRd  = hostRd && !hostWr && !hostSel;
  assign dataAcc = hostSel && (hostWr || hostRd);
  assign live    = (remainQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      remainQ <= '0;
      errQ    <= 1'b0;
    end else if (cmdWr) begin
      ptrQ    <= cmdBase;
      remainQ <= cmdValid ? cmdLen : '0;
      if (!cmdValid) errQ <= 1'b1;
    end else begin
      if (dataAcc && live) begin
        ptrQ    <= ptrQ + PTR_W'(1);
        remainQ <= remainQ - CNT_W'(1);
      end
      if (statRd) errQ <= 1'b0;
    end
  end

  assign bytePtr         = ptrQ;
  assign dpStb.wrByte    = hostSel && hostWr && live;
  assign dpStb.byteLive  = hostSel && live;
  assign statusByte      = {6'b0, live, errQ};

  // R2: the owed count never exceeds the aggregate length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    remainQ <= CNT_W'(MAP_BYTES));

  // R7: a bad command owes nothing and raises the flag
  a_r7_bad_cmd_flags: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !cmdValid |=> errQ && remainQ == '0);

  // R6: a good command always opens a transfer
  a_r6_cmd_opens: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdValid |=> live);

  // R4: each live data access steps the pointer by one
  a_r4_ptr_steps: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc && live |=> ptrQ == $past(ptrQ) + PTR_W'(1));

  // R5: accesses after exhaustion move nothing
  a_r5_exhausted_idle: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc && !live |=> $stable(ptrQ) && remainQ == '0);

endmodule

// File: rtl/irp_datapath.sv
module irp_datapath #(
  parameter int TOTAL = 51,
  parameter int PTR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  irp_pkg::dpStrobe_t  dpStb,
  input  logic [PTR_W-1:0]    bytePtr,
  input  logic [7:0]          wrData,
  output logic [7:0]          dataOut
);
  import irp_pkg::*;

  logic [TOTAL-1:0][7:0] storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeQ <= '0;
    end else if (dpStb.wrByte) begin
      for (int i = 0; i < TOTAL; i++) begin
        if (bytePtr == PTR_W'(i)) storeQ[i] <= wrData;
      end
    end
  end

  always_comb begin
    dataOut = 8'h00;
    if (dpStb.byteLive && int'(bytePtr) < TOTAL) dataOut = storeQ[bytePtr];
  end

  // R5: storage only changes under a write strobe
  a_r5_store_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !dpStb.wrByte |=> $stable(storeQ));

  // R4: a live pointer always lands inside the store
  a_r4_ptr_in_store: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.byteLive |-> int'(bytePtr) < TOTAL);

endmodule

// File: rtl/irp_port.sv
module irp_port #(
  parameter int COEF_BYTES = 16,
  parameter int GAIN_REGS  = 6,
  parameter int MUX_REGS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata
);
  import irp_pkg::*;

  localparam int MAP_BYTES = 2 * COEF_BYTES + 2 * GAIN_REGS + 2;
  localparam int TOTAL     = MAP_BYTES + MUX_REGS + 1;
  localparam int PTR_W     = $clog2(TOTAL);
  localparam int CNT_W     = $clog2(MAP_BYTES + 1);

  logic [PTR_W-1:0] cmdBase, bytePtr;
  logic [CNT_W-1:0] cmdLen;
  logic             cmdValid;
  dpStrobe_t        dpStb;
  logic [7:0]       statusByte, dataOut;

  irp_decode #(
    .COEF_BYTES(COEF_BYTES), .GAIN_REGS(GAIN_REGS), .MUX_REGS(MUX_REGS),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_decode (
    .cmdByte(hostWdata), .cmdBase(cmdBase), .cmdLen(cmdLen), .cmdValid(cmdValid)
  );

  irp_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W), .MAP_BYTES(MAP_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .cmdBase(cmdBase), .cmdLen(cmdLen), .cmdValid(cmdValid),
    .bytePtr(bytePtr), .dpStb(dpStb), .statusByte(statusByte)
  );

  irp_datapath #(.TOTAL(TOTAL), .PTR_W(PTR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .bytePtr(bytePtr),
    .wrData(hostWdata), .dataOut(dataOut)
  );

  assign hostRdata = hostSel ? dataOut : statusByte;

endmodule

// File: tb/irp_port_bench.sv
module irp_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;

  int nChecks = 0, nFails = 0;
  logic [7:0] model [51];
  int mPtr = 0, mRem = 0;
  bit mErr = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irp_port u_irp_port (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  // Expected layout from R2/R3: mapping group first, then mux, then init
  function automatic void expDecode(input logic [7:0] c, output int b, output int n);
    int v = int'(c);
    b = 0; n = 0;
    if (v == 'h21) begin b = 50; n = 1; end
    else if (v >= 'h41 && v <= 'h44) begin b = 46 + v - 'h41; n = 1; end
    else if (v == 'h61) begin b = 0; n = 16; end
    else if (v == 'h62) begin b = 16; n = 16; end
    else if (v >= 'h63 && v <= 'h68) begin b = 32 + 2 * (v - 'h63); n = 2; end
    else if (v == 'h69) begin b = 44; n = 1; end
    else if (v == 'h6A) begin b = 45; n = 1; end
    else if (v == 'h6B) begin b = 0; n = 46; end
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic busCycle(input logic sel, input logic wr, input logic rd,
                          input logic [7:0] wd, output logic [7:0] got);
    @(negedge clk);
    hostSel = sel; hostWr = wr; hostRd = rd; hostWdata = wd;
    #5 got = hostRdata;
    @(posedge clk);
    #1 hostWr = 1'b0; hostRd = 1'b0;
  endtask

  task automatic doCmd(input logic [7:0] c);
    logic [7:0] g;
    int b, n;
    busCycle(1'b0, 1'b1, 1'b0, c, g);
    expDecode(c, b, n);
    mPtr = b; mRem = n;
    if (n == 0) mErr = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] d);
    logic [7:0] g;
    busCycle(1'b1, 1'b1, 1'b0, d, g);
    if (mRem > 0) begin model[mPtr] = d; mPtr++; mRem--; end
  endtask

  task automatic doRead(input string tag);
    logic [7:0] g, e;
    busCycle(1'b1, 1'b0, 1'b1, 8'h00, g);
    e = (mRem > 0) ? model[mPtr] : 8'h00;
    check(tag, g, e);
    if (mRem > 0) begin mPtr++; mRem--; end
  endtask

  task automatic doStatus(input string tag);
    logic [7:0] g;
    busCycle(1'b0, 1'b0, 1'b1, 8'h00, g);
    check(tag, g, {6'b0, (mRem > 0), mErr});
    mErr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [18];
    void'($urandom(32'd20250611));
    for (int i = 0; i < 51; i++) model[i] = 8'h00;
    codes[0] = 8'h21;
    for (int i = 0; i < 4; i++) codes[1 + i] = 8'h41 + 8'(i);
    for (int i = 0; i < 11; i++) codes[5 + i] = 8'h61 + 8'(i);
    codes[16] = 8'h63; codes[17] = 8'h6B;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9: reset state through the ports
    doStatus("R9 status after reset");
    doRead("R9 data read idle");
    doCmd(8'h6B);
    doStatus("R8 pending after aggregate cmd");
    for (int i = 0; i < 46; i++) doRead("R9 map byte zero");
    doCmd(8'h21); doRead("R9 init zero");
    for (int i = 0; i < 4; i++) begin doCmd(8'h41 + 8'(i)); doRead("R9 mux zero"); end

    // R2/R4: fill a 16-byte register, read it back, then exhaust
    doCmd(8'h61);
    for (int i = 0; i < 16; i++) doWrite(8'hA0 + 8'(i));
    doStatus("R8 clear after 16 bytes");
    doWrite(8'hFF);
    doCmd(8'h61);
    for (int i = 0; i < 16; i++) doRead("R4 lsb-first readback");
    doRead("R5 read past count");

    // R1: same register number, different groups
    doCmd(8'h21); doWrite(8'h5A);
    doCmd(8'h41); doWrite(8'hC3);
    doCmd(8'h21); doRead("R1 init distinct from mux");
    doCmd(8'h61); doRead("R1 map distinct from init");

    // R3: last gain and mode bytes seen through the aggregate
    doCmd(8'h68); doWrite(8'h11); doWrite(8'h22);
    doCmd(8'h69); doWrite(8'h33);
    doCmd(8'h6A); doWrite(8'h44);
    doCmd(8'h6B);
    for (int i = 0; i < 46; i++) doRead("R3 aggregate order");
    doRead("R5 aggregate exhausted");
    doCmd(8'h6B);
    for (int i = 0; i < 46; i++) doWrite(8'(i * 7 + 1));
    doCmd(8'h63); doRead("R3 aggregate write hits gain"); doRead("R3 gain high byte");

    // R6: restart mid-transfer
    doCmd(8'h62); doWrite(8'hE1); doWrite(8'hE2); doWrite(8'hE3);
    doCmd(8'h6A); doStatus("R6 restart owes new count");
    doWrite(8'h9C);
    doCmd(8'h62); doRead("R6 partial bytes kept"); doRead("R6 partial second");
    doCmd(8'h6A); doRead("R6 restarted register");

    // R7: unknown codes
    doCmd(8'h6C); doStatus("R7 error after 0x6C");
    doStatus("R7 error cleared by read");
    doCmd(8'h45); doWrite(8'h77); doRead("R5 data after bad cmd");
    doCmd(8'h20); doCmd(8'h80); doStatus("R7 sticky over two bad cmds");
    doCmd(8'h41); doRead("R7 mux untouched by bad write");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] c;
      int b, n, k;
      if ($urandom_range(0, 7) == 0) c = 8'($urandom_range(0, 255));
      else c = codes[$urandom_range(0, 17)];
      doCmd(c);
      expDecode(c, b, n);
      k = $urandom_range(0, n + 2);
      for (int j = 0; j < k; j++) begin
        case ($urandom_range(0, 4))
          0, 1: doWrite(8'($urandom_range(0, 255)));
          2, 3: doRead((mRem > 0) ? "R4 random read" : "R5 random read");
          default: doStatus((mErr) ? "R7 random status" : "R8 random status");
        endcase
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule